// File: doc/BRIEF.md
# Bus Controller Transmit Sequencer

This block sends one bus-controller message onto a dual-redundant serial command/response bus of the MIL-STD-1553 kind. The host loads a 16-bit command word into a register and queues data words into a 32-entry transmit FIFO. It then starts the message in one of two ways: by raising an external start pin, or by setting the start bit of the control register. The sequencer sends the command word and then the number of data words that the command word asks for. All words go out back to back, with no gap between them.

A single Manchester-II word encoder produces the serial waveform. A bus-select bit in the control register steers the encoder to bus A or bus B, and each bus has its own transmit-enable output. The host may keep writing the FIFO while the message is on the wire. The message length has a hard upper limit of one command word plus 32 data words. If the FIFO runs dry before the requested count is reached, the block ends the message early and flags an underrun.

Top module: `bc_tx_sequencer`

## Requirements
- R1: After synchronous reset, busy_o, underrun_o, fifo_full_o, txen_a_o, txen_b_o, tx_a_o and tx_b_o are all 0, and the FIFO is empty.
- R2: The block is idle and a start is accepted in either of two cases. The first is a rising edge of start_pin_i. The second is a control-register write (reg_addr_i=0) with reg_wdata_i[0]=1 while the stored start bit is 0. A control write of 1 while the stored start bit is already 1 starts nothing.
- R3: Control bit 1, taken at the accepted start, selects the bus: 0 selects bus A and 1 selects bus B. During the message only the selected bus has its enable high and carries the waveform. The other bus, and both buses when idle, hold enable and data at 0.
- R4: Every word lasts 40 half-bit slots of HALF_BIT_CLKS clocks each. The first 6 slots are the sync: high,high,high,low,low,low for the command word, and low,low,low,high,high,high for a data word. Next come the 16 data bits, most significant bit first, each sent as 1 = high-then-low and 0 = low-then-high. The last bit is an odd-parity bit over the 16 data bits, encoded the same way.
- R5: The FIFO holds 32 words. fifo_full_o is high when it holds 32. A write while it is full is dropped. Writes made during a message are accepted and may feed that message.
- R6: The data word count is bits 4:0 of the command word, where 0 means 32. Data words follow the command word with no gap. FIFO words beyond that count are not sent and stay queued for the next message.
- R7: If a data word is due and the FIFO is empty, the message ends at that word boundary: busy_o falls and underrun_o is set. underrun_o clears at the next accepted start.
- R8: busy_o rises in the cycle after the accepted start and stays high until the last parity half-slot of the last word has been sent, which is 40*HALF_BIT_CLKS cycles per word. Starts that arrive while busy_o is high are ignored.
- R9: The command register (reg_addr_i=1) is sampled when a start is accepted. Writing it during a message affects only the next message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_pin_i | input | 1 | External start; a rising edge requests a message |
| reg_wr_i | input | 1 | Host register write strobe |
| reg_addr_i | input | 1 | 0 = control (bit0 start, bit1 bus), 1 = command word |
| reg_wdata_i | input | 16 | Host register write data |
| fifo_wr_i | input | 1 | Transmit FIFO write strobe |
| fifo_wdata_i | input | 16 | Transmit FIFO write data |
| fifo_full_o | output | 1 | FIFO holds its maximum number of words |
| busy_o | output | 1 | Message in progress |
| underrun_o | output | 1 | Last message ended early on an empty FIFO |
| txen_a_o | output | 1 | Bus A driver enable |
| tx_a_o | output | 1 | Bus A encoded serial data |
| txen_b_o | output | 1 | Bus B driver enable |
| tx_b_o | output | 1 | Bus B encoded serial data |

## Verification
The bench builds the block with HALF_BIT_CLKS=2 and the default 32-word FIFO, so one word takes 80 cycles. At that setting a full 33-word message lasts 2640 cycles, short enough to run the length cap, a full FIFO with one dropped write, an underrun and leftover words carried into a following message, all in one short run. Because the half-bit period is more than one clock, every slot boundary of the waveform is still compared cycle by cycle, which a one-clock slot would hide.

// File: rtl/bctx_pkg.sv
package bctx_pkg;

    localparam int WORD_W     = 16;
    localparam int SLOTS      = 40;
    localparam int SYNC_SLOTS = 6;
    localparam int SLOT_W     = 6;
    localparam int CNT_W      = 6;

    typedef enum logic {BUS_A = 1'b0, BUS_B = 1'b1} bus_sel_e;
    typedef enum logic {SQ_IDLE = 1'b0, SQ_RUN = 1'b1} seq_state_e;
    typedef enum logic {HR_CTRL = 1'b0, HR_CMD = 1'b1} host_reg_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              is_cmd;
    } tx_word_t;

    typedef struct packed {
        logic     go;
        bus_sel_e bus;
    } start_req_t;

    function automatic logic [CNT_W-1:0] word_count(input logic [4:0] field);
        return (field == 5'd0) ? CNT_W'(32) : {1'b0, field};
    endfunction

    function automatic logic slot_level(input tx_word_t w, input logic [SLOT_W-1:0] s);
        logic [4:0] k;
        logic       b;
        if (s < 6'(SYNC_SLOTS)) begin
            return w.is_cmd ? (s < 6'd3) : (s >= 6'd3);
        end else if (s < 6'(SLOTS - 2)) begin
            k = 5'(s - 6'(SYNC_SLOTS));
            b = w.data[4'(4'd15 - k[4:1])];
            return k[0] ? ~b : b;
        end else begin
            b = ~^w.data;
            return (s == 6'(SLOTS - 2)) ? b : ~b;
        end
    endfunction

endpackage

// File: rtl/bctx_fifo.sv
module bctx_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         pop_i,
    output logic [W-1:0] rdata_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_wr, do_pop;

    assign full_o  = (cnt == CW'(DEPTH));
    assign empty_o = (cnt == '0);
    assign do_wr   = wr_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign rdata_o = mem[rp];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr)  wp <= nxt(wp);
            if (do_pop) rp <= nxt(rp);
            case ({do_wr, do_pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/bctx_hostregs.sv
module bctx_hostregs
    import bctx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_pin_i,
    input  logic              reg_wr_i,
    input  logic              reg_addr_i,
    input  logic [WORD_W-1:0] reg_wdata_i,
    output start_req_t        req_o,
    output logic [WORD_W-1:0] cmd_o
);
    logic              pin_q;
    logic              go_bit_q;
    bus_sel_e          bus_q;
    logic [WORD_W-1:0] cmd_q;
    logic              ctrl_wr, cmd_wr;

    assign ctrl_wr = reg_wr_i && (host_reg_e'(reg_addr_i) == HR_CTRL);
    assign cmd_wr  = reg_wr_i && (host_reg_e'(reg_addr_i) == HR_CMD);

    always_comb begin
        req_o.go  = (start_pin_i && !pin_q) ||
                    (ctrl_wr && reg_wdata_i[0] && !go_bit_q);
        req_o.bus = ctrl_wr ? bus_sel_e'(reg_wdata_i[1]) : bus_q;
    end

    assign cmd_o = cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q    <= 1'b0;
            go_bit_q <= 1'b0;
            bus_q    <= BUS_A;
            cmd_q    <= '0;
        end else begin
            pin_q <= start_pin_i;
            if (ctrl_wr) begin
                go_bit_q <= reg_wdata_i[0];
                bus_q    <= bus_sel_e'(reg_wdata_i[1]);
            end
            if (cmd_wr) cmd_q <= reg_wdata_i;
        end
    end
endmodule

// File: rtl/bctx_encoder.sv
module bctx_encoder
    import bctx_pkg::*;
#(
    parameter int HALF_BIT_CLKS = 50
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     load_i,
    input  tx_word_t word_i,
    output logic     level_o,
    output logic     last_o
);
    localparam int HW = (HALF_BIT_CLKS > 1) ? $clog2(HALF_BIT_CLKS) : 1;

    tx_word_t          word_q;
    logic              active_q;
    logic [SLOT_W-1:0] slot_q;
    logic [HW-1:0]     hcnt_q;
    logic              slot_end;

    assign slot_end = (hcnt_q == HW'(HALF_BIT_CLKS - 1));
    assign last_o   = active_q && slot_end && (slot_q == SLOT_W'(SLOTS - 1));
    assign level_o  = active_q && slot_level(word_q, slot_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q   <= '0;
            active_q <= 1'b0;
            slot_q   <= '0;
            hcnt_q   <= '0;
        end else if (load_i) begin
            word_q   <= word_i;
            active_q <= 1'b1;
            slot_q   <= '0;
            hcnt_q   <= '0;
        end else if (active_q) begin
            if (slot_end) begin
                hcnt_q <= '0;
                if (slot_q == SLOT_W'(SLOTS - 1)) active_q <= 1'b0;
                else                              slot_q   <= slot_q + SLOT_W'(1);
            end else begin
                hcnt_q <= hcnt_q + HW'(1);
            end
        end
    end
endmodule

// File: rtl/bctx_seq.sv
module bctx_seq
    import bctx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  start_req_t        req_i,
    input  logic [WORD_W-1:0] cmd_i,
    input  logic              enc_last_i,
    input  logic              fifo_empty_i,
    input  logic [WORD_W-1:0] fifo_data_i,
    output logic              load_o,
    output tx_word_t          load_word_o,
    output logic              pop_o,
    output logic              busy_o,
    output bus_sel_e          bus_o,
    output logic              underrun_o
);
    seq_state_e       state_q;
    logic [CNT_W-1:0] left_q;
    bus_sel_e         bus_q;
    logic             und_q;
    logic             start_ok, need_data;

    assign start_ok  = (state_q == SQ_IDLE) && req_i.go;
    assign need_data = (state_q == SQ_RUN) && enc_last_i && (left_q != '0);

    always_comb begin
        load_o      = 1'b0;
        pop_o       = 1'b0;
        load_word_o = '{data: cmd_i, is_cmd: 1'b1};
        if (start_ok) begin
            load_o = 1'b1;
        end else if (need_data && !fifo_empty_i) begin
            load_o      = 1'b1;
            pop_o       = 1'b1;
            load_word_o = '{data: fifo_data_i, is_cmd: 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            left_q  <= '0;
            bus_q   <= BUS_A;
            und_q   <= 1'b0;
        end else if (start_ok) begin
            state_q <= SQ_RUN;
            left_q  <= word_count(cmd_i[4:0]);
            bus_q   <= req_i.bus;
            und_q   <= 1'b0;
        end else if (state_q == SQ_RUN && enc_last_i) begin
            if (left_q == '0) begin
                state_q <= SQ_IDLE;
            end else if (fifo_empty_i) begin
                state_q <= SQ_IDLE;
                und_q   <= 1'b1;
            end else begin
                left_q <= left_q - CNT_W'(1);
            end
        end
    end

    assign busy_o     = (state_q == SQ_RUN);
    assign bus_o      = bus_q;
    assign underrun_o = und_q;
endmodule

// File: rtl/bc_tx_sequencer.sv
module bc_tx_sequencer
    import bctx_pkg::*;
#(
    parameter int HALF_BIT_CLKS = 50,
    parameter int FIFO_DEPTH    = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_pin_i,
    input  logic        reg_wr_i,
    input  logic        reg_addr_i,
    input  logic [15:0] reg_wdata_i,
    input  logic        fifo_wr_i,
    input  logic [15:0] fifo_wdata_i,
    output logic        fifo_full_o,
    output logic        busy_o,
    output logic        underrun_o,
    output logic        txen_a_o,
    output logic        tx_a_o,
    output logic        txen_b_o,
    output logic        tx_b_o
);
    start_req_t        req;
    logic [WORD_W-1:0] cmd_word;
    logic [WORD_W-1:0] fifo_data;
    logic              fifo_empty, pop, load, enc_last, level, busy;
    tx_word_t          load_word;
    bus_sel_e          bus;

    bctx_hostregs u_regs (
        .clk(clk), .rst(rst), .start_pin_i(start_pin_i),
        .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .req_o(req), .cmd_o(cmd_word)
    );

    bctx_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
        .clk(clk), .rst(rst), .wr_i(fifo_wr_i), .wdata_i(fifo_wdata_i),
        .pop_i(pop), .rdata_o(fifo_data), .empty_o(fifo_empty), .full_o(fifo_full_o)
    );

    bctx_seq u_seq (
        .clk(clk), .rst(rst), .req_i(req), .cmd_i(cmd_word),
        .enc_last_i(enc_last), .fifo_empty_i(fifo_empty), .fifo_data_i(fifo_data),
        .load_o(load), .load_word_o(load_word), .pop_o(pop),
        .busy_o(busy), .bus_o(bus), .underrun_o(underrun_o)
    );

    bctx_encoder #(.HALF_BIT_CLKS(HALF_BIT_CLKS)) u_enc (
        .clk(clk), .rst(rst), .load_i(load), .word_i(load_word),
        .level_o(level), .last_o(enc_last)
    );

    assign busy_o   = busy;
    assign txen_a_o = busy && (bus == BUS_A);
    assign txen_b_o = busy && (bus == BUS_B);
    assign tx_a_o   = txen_a_o && level;
    assign tx_b_o   = txen_b_o && level;
endmodule

// File: rtl/bctx_checker.sv
module bctx_checker (
    input logic clk,
    input logic rst,
    input logic busy_o,
    input logic underrun_o,
    input logic txen_a_o,
    input logic tx_a_o,
    input logic txen_b_o,
    input logic tx_b_o
);
    // R3: never both buses driven
    a_r3_one_bus: assert property (@(posedge clk) disable iff (rst)
        !(txen_a_o && txen_b_o));

    // R3: a disabled bus carries no data
    a_r3_quiet_a: assert property (@(posedge clk) disable iff (rst)
        !txen_a_o |-> !tx_a_o);
    a_r3_quiet_b: assert property (@(posedge clk) disable iff (rst)
        !txen_b_o |-> !tx_b_o);

    // R3: bus choice holds for the whole message
    a_r3_bus_steady: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> ($stable(txen_a_o) && $stable(txen_b_o)));

    // R8: busy matches a driven bus
    a_r8_busy_enable: assert property (@(posedge clk) disable iff (rst)
        busy_o == (txen_a_o || txen_b_o));

    // R7: underrun is only raised as the message stops
    a_r7_underrun_stop: assert property (@(posedge clk) disable iff (rst)
        $rose(underrun_o) |-> (!busy_o && $fell(busy_o)));

    // R1: idle after reset
    a_r1_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> (!busy_o && !underrun_o));
endmodule

bind bc_tx_sequencer bctx_checker u_chk (
    .clk(clk), .rst(rst), .busy_o(busy_o), .underrun_o(underrun_o),
    .txen_a_o(txen_a_o), .tx_a_o(tx_a_o), .txen_b_o(txen_b_o), .tx_b_o(tx_b_o)
);

// File: tb/sim_bc_tx_sequencer.sv
module sim_bc_tx_sequencer;
    localparam int HALF  = 2;
    localparam int DEPTH = 32;
    localparam int WCYC  = 40 * HALF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_pin_i = 1'b0, reg_wr_i = 1'b0, reg_addr_i = 1'b0, fifo_wr_i = 1'b0;
    logic [15:0] reg_wdata_i = '0, fifo_wdata_i = '0;
    logic fifo_full_o, busy_o, underrun_o, txen_a_o, tx_a_o, txen_b_o, tx_b_o;

    int errors = 0, checks = 0, cyc = 0, busy_cnt = 0;
    bit live = 0;

    always #5 clk = ~clk;

    bc_tx_sequencer #(.HALF_BIT_CLKS(HALF), .FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .start_pin_i(start_pin_i), .reg_wr_i(reg_wr_i),
        .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .fifo_wr_i(fifo_wr_i),
        .fifo_wdata_i(fifo_wdata_i), .fifo_full_o(fifo_full_o), .busy_o(busy_o),
        .underrun_o(underrun_o), .txen_a_o(txen_a_o), .tx_a_o(tx_a_o),
        .txen_b_o(txen_b_o), .tx_b_o(tx_b_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    bit        mq[$];
    int        fq[$];
    bit        bus_m, und_m, pin_m, cstart_m, cbus_m;
    int        rem_m;
    bit [15:0] cmd_m;
    bit        m_busy, m_ctrl, m_trig, m_wrok;

    task automatic push_word(input bit [15:0] w, input bit is_cmd);
        bit lv[40];
        int ones = 0;
        for (int i = 0; i < 3; i++) begin
            lv[i]     = is_cmd;
            lv[i + 3] = !is_cmd;
        end
        for (int i = 0; i < 16; i++) begin
            lv[6 + 2*i]     = w[15 - i];
            lv[6 + 2*i + 1] = !w[15 - i];
            if (w[i]) ones++;
        end
        lv[38] = (ones % 2 == 0);
        lv[39] = !lv[38];
        for (int s = 0; s < 40; s++)
            for (int h = 0; h < HALF; h++) mq.push_back(lv[s]);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            mq.delete(); fq.delete();
            bus_m = 0; und_m = 0; pin_m = 0; cstart_m = 0; cbus_m = 0;
            rem_m = 0; cmd_m = '0;
        end else begin
            m_busy = (mq.size() != 0);
            m_ctrl = reg_wr_i && !reg_addr_i;
            m_trig = (start_pin_i && !pin_m) || (m_ctrl && reg_wdata_i[0] && !cstart_m);
            m_wrok = fifo_wr_i && (fq.size() < DEPTH);
            if (m_busy) begin
                void'(mq.pop_front());
                if (mq.size() == 0 && rem_m != 0) begin
                    if (fq.size() == 0) und_m = 1;
                    else begin
                        push_word(16'(fq.pop_front()), 0);
                        rem_m--;
                    end
                end
            end else if (m_trig) begin
                bus_m = m_ctrl ? reg_wdata_i[1] : cbus_m;
                und_m = 0;
                rem_m = (cmd_m[4:0] == 0) ? 32 : int'(cmd_m[4:0]);
                push_word(cmd_m, 1);
            end
            if (m_wrok) fq.push_back(int'(fifo_wdata_i));
            pin_m = start_pin_i;
            if (m_ctrl) begin
                cstart_m = reg_wdata_i[0];
                cbus_m   = reg_wdata_i[1];
            end
            if (reg_wr_i && reg_addr_i) cmd_m = reg_wdata_i;
        end
    end

    always @(negedge clk) begin
        if (!rst && live) begin
            bit eb, lv;
            eb = (mq.size() != 0);
            lv = eb ? mq[0] : 1'b0;
            chk("R8 busy_o", int'(busy_o), int'(eb));
            chk("R3 txen_a_o", int'(txen_a_o), int'(eb && !bus_m));
            chk("R3 txen_b_o", int'(txen_b_o), int'(eb && bus_m));
            chk("R4 tx_a_o", int'(tx_a_o), int'(eb && !bus_m && lv));
            chk("R4 tx_b_o", int'(tx_b_o), int'(eb && bus_m && lv));
            chk("R7 underrun_o", int'(underrun_o), int'(und_m));
            chk("R5 fifo_full_o", int'(fifo_full_o), int'(fq.size() == DEPTH));
        end
        if (busy_o) busy_cnt++;
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic host_wr(input bit a, input bit [15:0] d);
        reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 0;
    endtask

    task automatic push(input bit [15:0] d);
        fifo_wr_i = 1; fifo_wdata_i = d;
        @(negedge clk);
        fifo_wr_i = 0;
    endtask

    task automatic pulse_pin();
        start_pin_i = 1;
        @(negedge clk);
        start_pin_i = 0;
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        live = 1;
        // R1 reset state
        chk("R1 busy_o", int'(busy_o), 0);
        chk("R1 fifo_full_o", int'(fifo_full_o), 0);
        chk("R1 txen", int'(txen_a_o | txen_b_o | tx_a_o | tx_b_o), 0);
        chk("R1 underrun_o", int'(underrun_o), 0);

        // pin start, bus A, 3 data words
        host_wr(1, 16'h0843);
        push(16'hA5F0); push(16'h0001); push(16'hFFFF);
        host_wr(0, 16'h0000);
        busy_cnt = 0;
        pulse_pin();
        chk("R2 pin start busy", int'(busy_o), 1);
        wait_idle();
        chk("R8 length 4 words", busy_cnt, 4 * WCYC);

        // register start on bus B, one word loaded during message
        host_wr(1, 16'h1402);
        push(16'h8000);
        busy_cnt = 0;
        host_wr(0, 16'h0003);
        chk("R2 register start busy", int'(busy_o), 1);
        chk("R3 bus B enable", int'(txen_b_o), 1);
        push(16'h1234);
        wait_idle();
        chk("R5 on-the-fly fill length", busy_cnt, 3 * WCYC);
        host_wr(0, 16'h0002);

        // underrun: 4 asked, 2 present
        host_wr(1, 16'h0004);
        push(16'h0F0F); push(16'h7001);
        busy_cnt = 0;
        host_wr(0, 16'h0001);
        wait_idle();
        chk("R7 underrun length", busy_cnt, 3 * WCYC);
        chk("R7 underrun flag", int'(underrun_o), 1);
        host_wr(0, 16'h0000);

        // count field 0 -> 32 words, FIFO full, extra write dropped
        host_wr(1, 16'hF7E0);
        for (int i = 0; i < 32; i++) push(16'(i * 16'h0813 + 16'h0101));
        chk("R5 full after 32", int'(fifo_full_o), 1);
        push(16'hDEAD);
        chk("R5 still full", int'(fifo_full_o), 1);
        busy_cnt = 0;
        pulse_pin();
        chk("R7 underrun cleared on start", int'(underrun_o), 0);
        wait_idle();
        chk("R6 max length 33 words", busy_cnt, 33 * WCYC);
        chk("R5 FIFO drained", int'(fifo_full_o), 0);

        // leftover words carried to the next message
        host_wr(1, 16'h0022);
        push(16'h1111); push(16'h2222); push(16'h3333); push(16'h4444);
        busy_cnt = 0;
        pulse_pin();
        wait_idle();
        chk("R6 count 2 length", busy_cnt, 3 * WCYC);
        busy_cnt = 0;
        pulse_pin();
        wait_idle();
        chk("R6 leftovers sent", busy_cnt, 3 * WCYC);
        chk("R6 no underrun", int'(underrun_o), 0);

        // starts ignored while busy, command rewritten mid-message
        host_wr(1, 16'h0041);
        push(16'hC3C3);
        busy_cnt = 0;
        pulse_pin();
        repeat (5) @(negedge clk);
        pulse_pin();
        host_wr(0, 16'h0001);
        host_wr(1, 16'h0003);
        wait_idle();
        chk("R8 triggers ignored while busy", busy_cnt, 2 * WCYC);
        host_wr(0, 16'h0001);
        @(negedge clk);
        chk("R2 repeated 1 no start", int'(busy_o), 0);
        host_wr(0, 16'h0000);
        push(16'h0AAA); push(16'h0555); push(16'h8001);
        busy_cnt = 0;
        host_wr(0, 16'h0001);
        wait_idle();
        chk("R9 new command used next", busy_cnt, 4 * WCYC);
        repeat (4) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule